// File: doc/BRIEF.md
# FIR Test Stimulus Generator

This block is a synthesizable signal source for exercising a FIR filter in simulation or on hardware. It produces one signed sample on each enabled cycle and runs in one of two modes. The impulse mode sends one scaled unity value and then a run of zeros long enough for that value to pass every tap and pipeline stage. The sweep mode sends a full-scale square wave whose period grows step by step across a programmed range. Each sample is built only from the most positive and the most negative code, so different orderings of extremes line up with the coefficient set and expose overflow in the filter's accumulator.

A run starts with a one-cycle `start` pulse that captures the configuration. The filter under test sets the pace through `sample_en`. Each enabled cycle yields exactly one sample on `smp_out`, flagged by `smp_valid`. In impulse mode the unity value is one LSB shifted left by the number of low bits the filter drops, so after rounding or truncation the filter's output reproduces its taps. Set `win_len` to N+1+P, where N is the tap count and P the pipeline depth. A square period of at least twice the filter length turns the sweep into a step-response test.

Top module: `fir_stim_gen`

## Requirements
- R1: During and after a synchronous reset, `smp_valid`, `busy` and `done` are 0 and `smp_out` is 0.
- R2: A `start` pulse while `busy` is 0 captures `mode`, `shift_k`, `per_first`, `per_last`, `per_inc`, `cycles` and `win_len`, raises `busy` on the next cycle and clears `done`. A `start` while `busy` is 1 is ignored, and the running sequence is unchanged.
- R3: While `busy` is 1, every cycle with `sample_en` high produces exactly one sample, with `smp_valid` high for one cycle on the following cycle. A cycle with `sample_en` low produces no sample and does not advance the sequence.
- R4: Impulse mode (`mode`=0) first emits the value 1 shifted left by `shift_k`. A shift above DATA_W-2 is limited to DATA_W-2, so the value stays positive.
- R5: After the unity sample, impulse mode emits exactly `win_len` zero samples and then ends. With `win_len`=0 the run is the unity sample alone.
- R6: Sweep mode (`mode`=1) emits only the most positive code, 2^(DATA_W-1)-1, and the most negative code, -2^(DATA_W-1).
- R7: A square cycle of period p starts high. It holds the positive code for ceil(p/2) samples and then the negative code for floor(p/2) samples, so an odd period gives its extra sample to the high half.
- R8: Each period is played for `cycles` full square cycles (0 counts as 1). The period then grows by `per_inc`.
- R9: The sweep starts at `per_first` (values below 2 count as 2). It ends after the period whose successor, p+`per_inc`, would exceed `per_last`, or after the first period when `per_inc` is 0.
- R10: `done` rises on the same cycle as the run's last valid sample, as `busy` falls. It stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run and capture the configuration |
| mode | input | 1 | 0 selects impulse, 1 selects square sweep |
| shift_k | input | K_W | Left shift applied to the unity LSB |
| per_first | input | PER_W | First square period, in samples |
| per_last | input | PER_W | Upper bound on the square period |
| per_inc | input | PER_W | Period increment between steps |
| cycles | input | CYC_W | Full square cycles played per period |
| win_len | input | WIN_W | Zero samples following the impulse |
| sample_en | input | 1 | Request one sample this cycle |
| smp_out | output | DATA_W | Signed sample |
| smp_valid | output | 1 | `smp_out` holds a new sample |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |

## Verification
Each enabled cycle's sample appears one clock later through a single output register. The bench therefore raises `sample_en` at a falling edge and reads `smp_valid` and `smp_out` at the next falling edge, after the rising edge that registered them. `busy` is checked one clock after the accepting `start`. `done` is read at the falling edge that carries the last valid sample and must already be high there, with `busy` low. The collected sample stream is compared element by element against a sequence that the bench builds from the mode, the period range, the increment and the cycle count.

// File: rtl/fir_stim_pkg.sv
package fir_stim_pkg;

    typedef enum logic {
        MODE_IMPULSE = 1'b0,
        MODE_SWEEP   = 1'b1
    } stim_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Smallest square period that has both a high and a low half.
    localparam int MIN_PERIOD = 2;

    function automatic int clamp_int(input int v, input int hi);
        return (v > hi) ? hi : v;
    endfunction

endpackage

// File: rtl/fir_stim_impulse.sv
module fir_stim_impulse
    import fir_stim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int K_W    = 4,
    parameter int WIN_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init,
    input  logic                     step,
    input  logic [K_W-1:0]           shift_k,
    input  logic [WIN_W-1:0]         win_len,
    output logic signed [DATA_W-1:0] sample,
    output logic                     last
);
    localparam int K_LIMIT = DATA_W - 2;

    logic [K_W-1:0]     k_q;
    logic [WIN_W-1:0]   win_q;
    logic [WIN_W-1:0]   zero_cnt;
    logic               first;
    logic signed [DATA_W-1:0] unity;
    int                 k_eff;

    always_comb begin
        k_eff  = clamp_int(int'(k_q), K_LIMIT);
        unity  = DATA_W'(1) << k_eff;
        sample = first ? unity : '0;
        last   = first ? (win_q == '0) : (zero_cnt + WIN_W'(1) == win_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q      <= '0;
            win_q    <= '0;
            zero_cnt <= '0;
            first    <= 1'b1;
        end else if (init) begin
            k_q      <= shift_k;
            win_q    <= win_len;
            zero_cnt <= '0;
            first    <= 1'b1;
        end else if (step) begin
            if (first) first <= 1'b0;
            else       zero_cnt <= zero_cnt + WIN_W'(1);
        end
    end

    // R5: the zero counter never passes the programmed window.
    assert_zero_window_R5: assert property (@(posedge clk) disable iff (rst)
        zero_cnt <= win_q);

    // R5: once the unity sample is out, no second one follows within the run.
    assert_single_unity_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !init) |=> (!first || $past(init)) || $past(first && win_q == '0));

endmodule

// File: rtl/fir_stim_square.sv
module fir_stim_square
    import fir_stim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PER_W  = 12,
    parameter int CYC_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init,
    input  logic                     step,
    input  logic [PER_W-1:0]         per_first,
    input  logic [PER_W-1:0]         per_last,
    input  logic [PER_W-1:0]         per_inc,
    input  logic [CYC_W-1:0]         cycles,
    output logic signed [DATA_W-1:0] sample,
    output logic                     last
);
    localparam logic signed [DATA_W-1:0] LVL_HI = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] LVL_LO = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [PER_W-1:0]         P_MIN  = PER_W'(MIN_PERIOD);

    logic [PER_W-1:0] last_q, inc_q, per, pos;
    logic [CYC_W-1:0] cyc_q, cyc_cnt;
    logic [PER_W:0]   per_plus1, per_next;
    logic [PER_W-1:0] high_len;
    logic             end_of_cycle, end_of_group, final_period;

    always_comb begin
        per_plus1    = {1'b0, per} + (PER_W+1)'(1);
        high_len     = per_plus1[PER_W:1];
        per_next     = {1'b0, per} + {1'b0, inc_q};
        end_of_cycle = (pos == per - PER_W'(1));
        end_of_group = (cyc_cnt == cyc_q - CYC_W'(1));
        final_period = (inc_q == '0) || (per_next > {1'b0, last_q});
        sample       = (pos < high_len) ? LVL_HI : LVL_LO;
        last         = end_of_cycle && end_of_group && final_period;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= P_MIN;
            inc_q   <= '0;
            cyc_q   <= CYC_W'(1);
            per     <= P_MIN;
            pos     <= '0;
            cyc_cnt <= '0;
        end else if (init) begin
            last_q  <= per_last;
            inc_q   <= per_inc;
            cyc_q   <= (cycles == '0) ? CYC_W'(1) : cycles;
            per     <= (per_first < P_MIN) ? P_MIN : per_first;
            pos     <= '0;
            cyc_cnt <= '0;
        end else if (step) begin
            if (end_of_cycle) begin
                pos <= '0;
                if (end_of_group) begin
                    cyc_cnt <= '0;
                    if (!final_period) per <= per_next[PER_W-1:0];
                end else begin
                    cyc_cnt <= cyc_cnt + CYC_W'(1);
                end
            end else begin
                pos <= pos + PER_W'(1);
            end
        end
    end

    // R9: the active period never drops below two samples.
    assert_period_floor_R9: assert property (@(posedge clk) disable iff (rst)
        per >= P_MIN);

    // R7: the position inside a square cycle stays below the period.
    assert_pos_bound_R7: assert property (@(posedge clk) disable iff (rst)
        pos < per);

    // R8: after a full group the period grows by exactly the increment.
    assert_period_advance_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !init && end_of_cycle && end_of_group && !final_period)
        |=> per == $past(per) + $past(inc_q));

    // R8: the period is constant within a group.
    assert_period_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !init && !(end_of_cycle && end_of_group)) |=> $stable(per));

endmodule

// File: rtl/fir_stim_ctrl.sv
module fir_stim_ctrl
    import fir_stim_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     mode,
    input  logic                     sample_en,
    input  logic signed [DATA_W-1:0] imp_sample,
    input  logic                     imp_last,
    input  logic signed [DATA_W-1:0] sq_sample,
    input  logic                     sq_last,
    output logic                     accept,
    output logic                     imp_step,
    output logic                     sq_step,
    output logic signed [DATA_W-1:0] smp_out,
    output logic                     smp_valid,
    output logic                     busy,
    output logic                     done
);
    localparam logic signed [DATA_W-1:0] LVL_HI = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] LVL_LO = {1'b1, {(DATA_W-1){1'b0}}};

    run_state_e state;
    stim_mode_e mode_q;
    logic       take;
    logic       cur_last;
    logic signed [DATA_W-1:0] cur_sample;

    always_comb begin
        busy       = (state == ST_RUN);
        accept     = start && (state == ST_IDLE);
        take       = busy && sample_en;
        imp_step   = take && (mode_q == MODE_IMPULSE);
        sq_step    = take && (mode_q == MODE_SWEEP);
        cur_sample = (mode_q == MODE_SWEEP) ? sq_sample : imp_sample;
        cur_last   = (mode_q == MODE_SWEEP) ? sq_last   : imp_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode_q    <= MODE_IMPULSE;
            smp_out   <= '0;
            smp_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (accept) begin
                state  <= ST_RUN;
                mode_q <= stim_mode_e'(mode);
                done   <= 1'b0;
            end else if (take) begin
                smp_valid <= 1'b1;
                smp_out   <= cur_sample;
                if (cur_last) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    // R10: a finished run and a running one never overlap.
    assert_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R3: each valid sample comes from an enabled cycle of a run.
    assert_valid_cause_R3: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ($past(sample_en) && $past(busy)));

    // R6: sweep samples are only ever the two extremes.
    assert_sweep_levels_R6: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode_q == MODE_SWEEP) |-> (smp_out == LVL_HI || smp_out == LVL_LO));

    // R2: busy rises on the cycle after an accepted start.
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R10: done only rises together with a valid sample.
    assert_done_with_last_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> smp_valid);

endmodule

// File: rtl/fir_stim_gen.sv
module fir_stim_gen
    import fir_stim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int K_W    = 4,
    parameter int PER_W  = 12,
    parameter int CYC_W  = 8,
    parameter int WIN_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     mode,
    input  logic [K_W-1:0]           shift_k,
    input  logic [PER_W-1:0]         per_first,
    input  logic [PER_W-1:0]         per_last,
    input  logic [PER_W-1:0]         per_inc,
    input  logic [CYC_W-1:0]         cycles,
    input  logic [WIN_W-1:0]         win_len,
    input  logic                     sample_en,
    output logic signed [DATA_W-1:0] smp_out,
    output logic                     smp_valid,
    output logic                     busy,
    output logic                     done
);
    logic accept, imp_step, sq_step, imp_last, sq_last;
    logic signed [DATA_W-1:0] imp_sample, sq_sample;

    fir_stim_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode       (mode),
        .sample_en  (sample_en),
        .imp_sample (imp_sample),
        .imp_last   (imp_last),
        .sq_sample  (sq_sample),
        .sq_last    (sq_last),
        .accept     (accept),
        .imp_step   (imp_step),
        .sq_step    (sq_step),
        .smp_out    (smp_out),
        .smp_valid  (smp_valid),
        .busy       (busy),
        .done       (done)
    );

    fir_stim_impulse #(.DATA_W(DATA_W), .K_W(K_W), .WIN_W(WIN_W)) u_imp (
        .clk     (clk),
        .rst     (rst),
        .init    (accept),
        .step    (imp_step),
        .shift_k (shift_k),
        .win_len (win_len),
        .sample  (imp_sample),
        .last    (imp_last)
    );

    fir_stim_square #(.DATA_W(DATA_W), .PER_W(PER_W), .CYC_W(CYC_W)) u_sq (
        .clk       (clk),
        .rst       (rst),
        .init      (accept),
        .step      (sq_step),
        .per_first (per_first),
        .per_last  (per_last),
        .per_inc   (per_inc),
        .cycles    (cycles),
        .sample    (sq_sample),
        .last      (sq_last)
    );

endmodule

// File: tb/fir_stim_gen_test.sv
module fir_stim_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int MAXN = 512;
    localparam logic signed [DW-1:0] HI = 16'sh7FFF;
    localparam logic signed [DW-1:0] LO = -16'sh8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [3:0]  shift_k = '0;
    logic [11:0] per_first = '0, per_last = '0, per_inc = '0;
    logic [7:0]  cycles = '0;
    logic [15:0] win_len = '0;
    logic sample_en = 1'b0;
    logic signed [DW-1:0] smp_out;
    logic smp_valid, busy, done;

    int total = 0;
    int bad = 0;
    logic signed [DW-1:0] got  [MAXN];
    logic signed [DW-1:0] expv [MAXN];

    fir_stim_gen uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .shift_k(shift_k),
        .per_first(per_first), .per_last(per_last), .per_inc(per_inc),
        .cycles(cycles), .win_len(win_len), .sample_en(sample_en),
        .smp_out(smp_out), .smp_valid(smp_valid), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    function automatic int build_imp(input int k, input int win);
        int kk = (k > DW-2) ? DW-2 : k;
        expv[0] = DW'(1) << kk;
        for (int i = 1; i <= win; i++) expv[i] = '0;
        return win + 1;
    endfunction

    function automatic int build_sweep(input int ps, input int pe, input int st, input int cy);
        int n = 0;
        int p = (ps < 2) ? 2 : ps;
        int c = (cy == 0) ? 1 : cy;
        while (1) begin
            for (int j = 0; j < c; j++)
                for (int i = 0; i < p; i++) begin
                    if (n < MAXN) expv[n] = (i < (p + 1) / 2) ? HI : LO;
                    n++;
                end
            if (st == 0 || p + st > pe) break;
            p += st;
        end
        return n;
    endfunction

    task automatic begin_run(input bit m, input int k, input int ps, input int pe,
                             input int st, input int cy, input int win, input string req);
        @(negedge clk);
        mode = m; shift_k = 4'(k); per_first = 12'(ps); per_last = 12'(pe);
        per_inc = 12'(st); cycles = 8'(cy); win_len = 16'(win);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {req, " R2 busy after start"}, int'(busy), 1);
        chk(done == 1'b0, {req, " R2 done cleared by start"}, int'(done), 0);
    endtask

    // Drives sample_en with a gap pattern, records every valid sample until done.
    task automatic capture(input int gap, input int poke_at, output int n, output bit done_ok,
                           output int stray);
        n = 0; done_ok = 0; stray = 0;
        for (int i = 0; i < 4000; i++) begin
            sample_en = (gap == 0) || (i % (gap + 1) == 0);
            start = (i == poke_at);
            if (i == poke_at) begin
                mode = ~mode; per_first = 12'd5; win_len = 16'd1; shift_k = 4'd9;
            end
            @(negedge clk);
            if (smp_valid && !sample_en) stray++;
            if (smp_valid) begin
                if (n < MAXN) got[n] = smp_out;
                n++;
            end
            if (done) begin
                done_ok = smp_valid && !busy;
                break;
            end
        end
        sample_en = 1'b0;
        start = 1'b0;
    endtask

    task automatic compare(input int n_got, input int n_exp, input string req);
        int first_bad = -1;
        chk(n_got == n_exp, {req, " sample count"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got && i < MAXN; i++)
            if (got[i] !== expv[i] && first_bad < 0) first_bad = i;
        if (first_bad >= 0)
            chk(1'b0, {req, " sample value"}, int'(got[first_bad]), int'(expv[first_bad]));
        else
            chk(1'b1, req, 0, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!smp_valid && !busy && !done && smp_out == 0, "R1 reset outputs",
            int'({smp_valid, busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!smp_valid && !busy && !done, "R1 idle after reset", int'({smp_valid, busy, done}), 0);
    endtask

    task automatic t_impulse_basic();
        int n, ne, stray; bit dok;
        begin_run(1'b0, 3, 0, 0, 0, 0, 10, "impulse k3");
        ne = build_imp(3, 10);
        capture(0, -1, n, dok, stray);
        compare(n, ne, "R4 R5 impulse k=3 win=10");
        chk(dok, "R10 done with last sample", int'(dok), 1);
        repeat (4) @(negedge clk);
        chk(done && !smp_valid, "R10 done sticky", int'(done), 1);
    endtask

    task automatic t_impulse_clamp();
        int n, ne, stray; bit dok;
        begin_run(1'b0, 15, 0, 0, 0, 0, 0, "impulse k15");
        ne = build_imp(15, 0);
        capture(0, -1, n, dok, stray);
        compare(n, ne, "R4 R5 shift clamp, empty window");
        chk(dok, "R10 done on single sample", int'(dok), 1);
    endtask

    task automatic t_impulse_gapped();
        int n, ne, stray; bit dok;
        begin_run(1'b0, 0, 0, 0, 0, 0, 6, "impulse gapped");
        ne = build_imp(0, 6);
        capture(2, 3, n, dok, stray);
        compare(n, ne, "R3 R2 gapped enable, start ignored while busy");
        chk(stray == 0, "R3 no sample without enable", stray, 0);
    endtask

    task automatic t_sweep_odd();
        int n, ne, stray; bit dok;
        begin_run(1'b1, 0, 3, 8, 2, 2, 0, "sweep 3..8");
        ne = build_sweep(3, 8, 2, 2);
        capture(0, -1, n, dok, stray);
        compare(n, ne, "R6 R7 R8 R9 sweep 3,5,7 x2");
        chk(dok, "R10 sweep done", int'(dok), 1);
    endtask

    task automatic t_sweep_floor();
        int n, ne, stray; bit dok;
        begin_run(1'b1, 0, 1, 4, 0, 0, 0, "sweep floor");
        ne = build_sweep(1, 4, 0, 0);
        capture(1, -1, n, dok, stray);
        compare(n, ne, "R9 R8 period floor, zero increment, zero cycles");
        chk(stray == 0, "R3 gapped sweep", stray, 0);
    endtask

    task automatic t_sweep_step_resp();
        int n, ne, stray; bit dok;
        begin_run(1'b1, 0, 120, 120, 5, 1, 0, "step response");
        ne = build_sweep(120, 120, 5, 1);
        capture(0, -1, n, dok, stray);
        compare(n, ne, "R7 R9 period 120 step response");
    endtask

    task automatic t_sweep_even_range();
        int n, ne, stray; bit dok;
        begin_run(1'b1, 0, 4, 16, 6, 1, 0, "sweep 4..16");
        ne = build_sweep(4, 16, 6, 1);
        capture(0, -1, n, dok, stray);
        compare(n, ne, "R8 R9 sweep 4,10,16 inclusive end");
    endtask

    initial begin
        t_reset();
        t_impulse_basic();
        t_impulse_clamp();
        t_impulse_gapped();
        t_sweep_odd();
        t_sweep_floor();
        t_sweep_step_resp();
        t_sweep_even_range();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule